// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It reads one first-level descriptor from memory and, when that descriptor points to a second-level table, one second-level descriptor. A first-level entry can map a whole 1 MB section directly. It can also point to a coarse table, which holds 64 KB and 4 KB pages, or to a fine table, which holds 64 KB, 4 KB and 1 KB pages. Along with the physical address the walker reports the region attributes (cacheable, bufferable, extension) and an ECC-enable decision. The ECC decision is derived from a protect flag that only first-level entries carry.

The walker takes a request when it is idle and issues descriptor reads on a port that allows one read outstanding at a time. Each read carries an ECC flag of its own, because the walker's own table fetches bypass translation. The walker then pulses `done` for one cycle with the result. When translation is off it makes no reads and returns the address unchanged, with every attribute cleared.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` stays low while a walk is in progress.
- R2: The first descriptor read goes to address {`tbl_base`, VA[31:20], 2'b00}. Every descriptor read carries `mem_rd_ecc` = `aux_ecc_en` AND `bus_ecc_en`.
- R3: First-level descriptor bits [1:0] select the entry kind: 00 fault, 01 coarse, 10 section, 11 fine. A section takes exactly one read and gives PA = {D[31:20], VA[19:0]}, with C = D[3], B = D[2] and X = D[5].
- R4: A coarse entry causes a second read at {D[31:10], VA[19:12], 2'b00}. In the second-level entry E, E[1:0] = 01 gives PA = {E[31:16], VA[15:0]}, 10 gives PA = {E[31:12], VA[11:0]}, and 11 is a fault.
- R5: A fine entry causes a second read at {D[31:12], VA[19:10], 2'b00}. In the second-level entry, 01 and 10 map as in R4, and 11 is a 1 KB page with PA = {E[31:10], VA[9:0]}.
- R6: A type of 00 at either level ends the walk with `fault` = 1, PA = 0, and C, B, X and `ecc_en` all 0.
- R7: For page mappings, C = E[3], B = E[2] and X = E[4] come from the second-level entry. The protect flag P is always first-level bit D[4]; second-level entries have no protect flag of their own.
- R8: When translation is on and the walk does not fault, `ecc_en` = P AND `bus_ecc_en`.
- R9: When `xlat_en` is low at acceptance, no read is issued. `done` rises in the cycle after acceptance with PA = VA, `fault` = 0, and C, B, X and `ecc_en` all 0.
- R10: For an instruction fetch (`req_ifetch` = 1), C is reported as described above, while B and X are reported 0.
- R11: `done` is high for exactly one cycle per request, and the walker is idle in the cycle that follows.
- R12: Each read is a one-cycle pulse of `mem_rd_valid`. A second read is issued only after `mem_rsp_valid` has answered the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_ifetch | input | 1 | Request is an instruction fetch |
| xlat_en | input | 1 | Translation enable |
| tbl_base | input | 18 | First-level table base, address bits [31:14] |
| aux_ecc_en | input | 1 | ECC enable for walker table reads |
| bus_ecc_en | input | 1 | Global ECC enable of the bus controller |
| mem_rd_valid | output | 1 | Descriptor read pulse |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_ecc | output | 1 | ECC enable tag for the read |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor data |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address |
| attr_c | output | 1 | Cacheable |
| attr_b | output | 1 | Bufferable |
| attr_x | output | 1 | Extension attribute |
| ecc_en | output | 1 | ECC enabled for the access |
| fault | output | 1 | Translation fault |

## Verification
The bench walks every combination of first-level kind and second-level type. Within each combination it varies C, B, X, the protect flag and the fetch type, and derives the ECC enables and the response latency from the loop index. This separates section from page mapping, coarse from fine indexing, and the 64 KB, 4 KB and 1 KB offset masks, and it catches a 1 KB page wrongly accepted from a coarse table. Pseudo-random address and descriptor bits expose any mis-sliced field. Runs with translation disabled and faulting walks confirm that all attributes are cleared. Mixing fetches with data accesses shows that B and X are suppressed only for fetches.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W  = 32;
  localparam int TBASE_W = 18;
  localparam int L1_IDX_LSB = 20;

  // first-level descriptor fields
  localparam int D1_B = 2;
  localparam int D1_C = 3;
  localparam int D1_P = 4;
  localparam int D1_X = 5;
  // second-level descriptor fields
  localparam int D2_B = 2;
  localparam int D2_C = 3;
  localparam int D2_X = 4;

  typedef enum logic [1:0] {
    K_FAULT  = 2'b00,
    K_COARSE = 2'b01,
    K_SECT   = 2'b10,
    K_FINE   = 2'b11
  } l1_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_RD,
    ST_L1_WT,
    ST_L2_RD,
    ST_L2_WT,
    ST_RESP
  } walk_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic c;
    logic b;
    logic x;
    logic ecc;
    logic fault;
  } walk_res_t;
endpackage

// File: rtl/pgwalk_rst_sync.sv
module pgwalk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/pgwalk_l1_dec.sv
module pgwalk_l1_dec
  import pgwalk_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [19:0]       va_lo,
  output l1_kind_t          kind,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] sect_pa,
  output logic              c,
  output logic              b,
  output logic              x,
  output logic              p
);
  logic unused_d1;

  assign kind = l1_kind_t'(desc[1:0]);
  assign c    = desc[D1_C];
  assign b    = desc[D1_B];
  assign x    = desc[D1_X];
  assign p    = desc[D1_P];
  assign unused_d1 = ^desc[9:6];

  assign sect_pa = {desc[31:20], va_lo[19:0]};

  always_comb begin
    if (kind == K_FINE) next_addr = {desc[31:12], va_lo[19:10], 2'b00};
    else                next_addr = {desc[31:10], va_lo[19:12], 2'b00};
  end
endmodule

// File: rtl/pgwalk_l2_dec.sv
module pgwalk_l2_dec
  import pgwalk_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [15:0]       va_lo,
  input  logic              fine,
  output logic [ADDR_W-1:0] pa,
  output logic              c,
  output logic              b,
  output logic              x,
  output logic              flt
);
  logic unused_d2;

  assign c = desc[D2_C];
  assign b = desc[D2_B];
  assign x = desc[D2_X];
  assign unused_d2 = ^desc[9:5];

  always_comb begin
    pa  = '0;
    flt = 1'b0;
    unique case (desc[1:0])
      2'b00: flt = 1'b1;
      2'b01: pa  = {desc[31:16], va_lo[15:0]};
      2'b10: pa  = {desc[31:12], va_lo[11:0]};
      2'b11: begin
        if (fine) pa  = {desc[31:10], va_lo[9:0]};
        else      flt = 1'b1;
      end
      default: flt = 1'b1;
    endcase
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_va,
  input  logic               req_ifetch,
  input  logic               xlat_en,
  input  logic [TBASE_W-1:0] tbl_base,
  input  logic               aux_ecc_en,
  input  logic               bus_ecc_en,
  output logic               mem_rd_valid,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  output logic               mem_rd_ecc,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data,
  output logic [ADDR_W-1:0]  l1_view,
  output logic [ADDR_W-1:0]  va_view,
  output logic               fine_view,
  input  l1_kind_t           l1_kind,
  input  logic [ADDR_W-1:0]  l1_next_addr,
  input  logic [ADDR_W-1:0]  l1_sect_pa,
  input  logic               l1_c,
  input  logic               l1_b,
  input  logic               l1_x,
  input  logic               l1_p,
  input  logic [ADDR_W-1:0]  l2_pa,
  input  logic               l2_c,
  input  logic               l2_b,
  input  logic               l2_x,
  input  logic               l2_fault,
  output logic               done,
  output walk_res_t          res
);
  walk_state_t        state_q, state_d;
  logic [ADDR_W-1:0]  va_q;
  logic [TBASE_W-1:0] tbase_q;
  logic               ifetch_q;
  logic               bus_ecc_q;
  logic               aux_ecc_q;
  logic [ADDR_W-1:0]  l1_q;
  walk_res_t          res_q, res_d;
  logic               ld_req, ld_l1, ld_res;

  function automatic walk_res_t form_res(
    input logic [ADDR_W-1:0] pa_i,
    input logic c_i, input logic b_i, input logic x_i,
    input logic p_i, input logic ifetch_i, input logic bus_i);
    walk_res_t r;
    r.pa    = pa_i;
    r.c     = c_i;
    r.b     = b_i & ~ifetch_i;
    r.x     = x_i & ~ifetch_i;
    r.ecc   = p_i & bus_i;
    r.fault = 1'b0;
    return r;
  endfunction

  function automatic walk_res_t fault_res();
    walk_res_t r;
    r       = '0;
    r.fault = 1'b1;
    return r;
  endfunction

  // next-state and load decisions
  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_l1   = 1'b0;
    ld_res  = 1'b0;
    res_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (xlat_en) begin
            state_d = ST_L1_RD;
          end else begin
            ld_res   = 1'b1;
            res_d.pa = req_va;
            state_d  = ST_RESP;
          end
        end
      end
      ST_L1_RD: state_d = ST_L1_WT;
      ST_L1_WT: begin
        if (mem_rsp_valid) begin
          ld_l1 = 1'b1;
          unique case (l1_kind)
            K_FAULT: begin
              ld_res  = 1'b1;
              res_d   = fault_res();
              state_d = ST_RESP;
            end
            K_SECT: begin
              ld_res  = 1'b1;
              res_d   = form_res(l1_sect_pa, l1_c, l1_b, l1_x, l1_p,
                                 ifetch_q, bus_ecc_q);
              state_d = ST_RESP;
            end
            default: state_d = ST_L2_RD;
          endcase
        end
      end
      ST_L2_RD: state_d = ST_L2_WT;
      ST_L2_WT: begin
        if (mem_rsp_valid) begin
          ld_res = 1'b1;
          if (l2_fault) res_d = fault_res();
          else          res_d = form_res(l2_pa, l2_c, l2_b, l2_x, l1_q[D1_P],
                                         ifetch_q, bus_ecc_q);
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      tbase_q   <= '0;
      ifetch_q  <= 1'b0;
      bus_ecc_q <= 1'b0;
      aux_ecc_q <= 1'b0;
    end else if (ld_req) begin
      va_q      <= req_va;
      tbase_q   <= tbl_base;
      ifetch_q  <= req_ifetch;
      bus_ecc_q <= bus_ecc_en;
      aux_ecc_q <= aux_ecc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     l1_q <= '0;
    else if (ld_l1) l1_q <= mem_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (ld_res) res_q <= res_d;
  end

  // outputs
  assign req_ready    = (state_q == ST_IDLE);
  assign done         = (state_q == ST_RESP);
  assign res          = res_q;
  assign mem_rd_valid = (state_q == ST_L1_RD) || (state_q == ST_L2_RD);
  assign mem_rd_ecc   = aux_ecc_q & bus_ecc_q;
  assign mem_rd_addr  = (state_q == ST_L1_RD)
                        ? {tbase_q, va_q[ADDR_W-1:L1_IDX_LSB], 2'b00}
                        : l1_next_addr;
  assign l1_view      = (state_q == ST_L1_WT) ? mem_rsp_data : l1_q;
  assign va_view      = va_q;
  assign fine_view    = (l1_q[1:0] == K_FINE);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_va,
  input  logic                req_ifetch,
  input  logic                xlat_en,
  input  logic [17:0]         tbl_base,
  input  logic                aux_ecc_en,
  input  logic                bus_ecc_en,
  output logic                mem_rd_valid,
  output logic [31:0]         mem_rd_addr,
  output logic                mem_rd_ecc,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  output logic                done,
  output logic [31:0]         pa,
  output logic                attr_c,
  output logic                attr_b,
  output logic                attr_x,
  output logic                ecc_en,
  output logic                fault
);
  logic              rst_sn;
  logic [ADDR_W-1:0] l1_view, va_view;
  logic              fine_view;
  l1_kind_t          l1_kind;
  logic [ADDR_W-1:0] l1_next_addr, l1_sect_pa;
  logic              l1_c, l1_b, l1_x, l1_p;
  logic [ADDR_W-1:0] l2_pa;
  logic              l2_c, l2_b, l2_x, l2_fault;
  walk_res_t         res;
  logic              unused_va;

  pgwalk_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  pgwalk_l1_dec l1_i (
    .desc(l1_view), .va_lo(va_view[19:0]), .kind(l1_kind),
    .next_addr(l1_next_addr), .sect_pa(l1_sect_pa),
    .c(l1_c), .b(l1_b), .x(l1_x), .p(l1_p)
  );

  pgwalk_l2_dec l2_i (
    .desc(mem_rsp_data), .va_lo(va_view[15:0]), .fine(fine_view),
    .pa(l2_pa), .c(l2_c), .b(l2_b), .x(l2_x), .flt(l2_fault)
  );

  pgwalk_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_sn),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_ifetch(req_ifetch), .xlat_en(xlat_en), .tbl_base(tbl_base),
    .aux_ecc_en(aux_ecc_en), .bus_ecc_en(bus_ecc_en),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ecc(mem_rd_ecc), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .l1_view(l1_view), .va_view(va_view), .fine_view(fine_view),
    .l1_kind(l1_kind), .l1_next_addr(l1_next_addr), .l1_sect_pa(l1_sect_pa),
    .l1_c(l1_c), .l1_b(l1_b), .l1_x(l1_x), .l1_p(l1_p),
    .l2_pa(l2_pa), .l2_c(l2_c), .l2_b(l2_b), .l2_x(l2_x),
    .l2_fault(l2_fault), .done(done), .res(res)
  );

  assign unused_va = ^va_view[31:20];
  assign pa     = res.pa;
  assign attr_c = res.c;
  assign attr_b = res.b;
  assign attr_x = res.x;
  assign ecc_en = res.ecc;
  assign fault  = res.fault;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic        req_ifetch,
  input logic        xlat_en,
  input logic        bus_ecc_en,
  input logic        mem_rd_valid,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic [31:0] pa,
  input logic        attr_c,
  input logic        attr_b,
  input logic        attr_x,
  input logic        ecc_en,
  input logic        fault
);
  logic        outst_q;
  logic        ifetch_a, xlat_a, bus_a;
  logic [31:0] va_a;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)             outst_q <= 1'b0;
    else if (mem_rd_valid)   outst_q <= 1'b1;
    else if (mem_rsp_valid)  outst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ifetch_a <= 1'b0;
      xlat_a   <= 1'b0;
      bus_a    <= 1'b0;
      va_a     <= '0;
    end else if (req_valid && req_ready) begin
      ifetch_a <= req_ifetch;
      xlat_a   <= xlat_en;
      bus_a    <= bus_ecc_en;
      va_a     <= req_va;
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_valid |-> !req_ready);
  assert_fault_clear_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && fault) |-> (pa == 32'd0 && !attr_c && !attr_b && !attr_x && !ecc_en));
  assert_ecc_gate_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && ecc_en) |-> (xlat_a && bus_a && !fault));
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !xlat_a) |-> (pa == va_a && !attr_c && !attr_b && !attr_x && !ecc_en && !fault));
  assert_fetch_attr_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && ifetch_a) |-> (!attr_b && !attr_x));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> (!done && req_ready));
  assert_single_rd_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_valid |-> !outst_q);
  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_valid |=> !mem_rd_valid);
endmodule

bind pgwalk_top pgwalk_chk chk_i (
  .clk(clk), .rst_sn(rst_sn), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_ifetch(req_ifetch), .xlat_en(xlat_en),
  .bus_ecc_en(bus_ecc_en), .mem_rd_valid(mem_rd_valid),
  .mem_rsp_valid(mem_rsp_valid), .done(done), .pa(pa), .attr_c(attr_c),
  .attr_b(attr_b), .attr_x(attr_x), .ecc_en(ecc_en), .fault(fault)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_ifetch, xlat_en;
  logic [31:0] req_va;
  logic [17:0] tbl_base;
  logic        aux_ecc_en, bus_ecc_en;
  logic        mem_rd_valid, mem_rd_ecc, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;
  logic        done, attr_c, attr_b, attr_x, ecc_en, fault;
  logic [31:0] pa;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_ifetch(req_ifetch), .xlat_en(xlat_en),
    .tbl_base(tbl_base), .aux_ecc_en(aux_ecc_en), .bus_ecc_en(bus_ecc_en),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ecc(mem_rd_ecc), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .pa(pa), .attr_c(attr_c),
    .attr_b(attr_b), .attr_x(attr_x), .ecc_en(ecc_en), .fault(fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int n);
    logic [31:0] h;
    h = 32'h9E3779B9 * (n + 7);
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    return h ^ (h >> 13);
  endfunction

  task automatic run_walk(input logic [31:0] va, input logic ifetch,
                          input logic xl, input logic bus, input logic aux,
                          input logic [31:0] d1, input logic [31:0] d2,
                          input int lat, input string tag);
    int          exp_reads;
    logic [31:0] e_a1, e_a2, e_pa, msk;
    logic        e_c, e_b, e_x, e_ecc, e_f;
    int          nreads, cd;
    bit          got;
    e_a1 = {tbl_base, va[31:20], 2'b00};
    e_a2 = (d1[1:0] == 2'b11) ? {d1[31:12], va[19:10], 2'b00}
                              : {d1[31:10], va[19:12], 2'b00};
    e_pa = 0; e_c = 0; e_b = 0; e_x = 0; e_f = 0;
    if (!xl) begin
      exp_reads = 0; e_pa = va;
    end else if (d1[1:0] == 2'b00) begin
      exp_reads = 1; e_f = 1;
    end else if (d1[1:0] == 2'b10) begin
      exp_reads = 1;
      e_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      e_c = d1[3]; e_b = d1[2]; e_x = d1[5];
    end else begin
      exp_reads = 2;
      if (d2[1:0] == 2'b00 || (d2[1:0] == 2'b11 && d1[1:0] == 2'b01)) e_f = 1;
      else begin
        msk  = (d2[1:0] == 2'b01) ? 32'h0000_FFFF :
               (d2[1:0] == 2'b10) ? 32'h0000_0FFF : 32'h0000_03FF;
        e_pa = (d2 & ~msk) | (va & msk);
        e_c = d2[3]; e_b = d2[2]; e_x = d2[4];
      end
    end
    if (ifetch) begin e_b = 0; e_x = 0; end
    e_ecc = xl && !e_f && d1[4] && bus;

    @(negedge clk);
    chk(req_ready, {tag, " R1 idle ready"}, 64'(req_ready), 64'd1);
    req_valid = 1; req_va = va; req_ifetch = ifetch; xlat_en = xl;
    bus_ecc_en = bus; aux_ecc_en = aux;
    nreads = 0; cd = 0; got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      req_valid = 0; mem_rsp_valid = 0;
      if (done) begin
        got = 1;
        chk({pa, attr_c, attr_b, attr_x, ecc_en, fault} ==
            {e_pa, e_c, e_b, e_x, e_ecc, e_f},
            {tag, " R3 R4 R5 R6 R7 R8 R9 R10 result"},
            64'({pa, attr_c, attr_b, attr_x, ecc_en, fault}),
            64'({e_pa, e_c, e_b, e_x, e_ecc, e_f}));
        chk(nreads == exp_reads, {tag, " R3 R9 R12 read count"},
            64'(nreads), 64'(exp_reads));
      end else begin
        if (cd > 0) begin
          cd = cd - 1;
          if (cd == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data  = (nreads == 1) ? d1 : d2;
          end
        end
        if (mem_rd_valid) begin
          nreads = nreads + 1;
          chk(!req_ready, {tag, " R1 busy"}, 64'(req_ready), 64'd0);
          chk(cd == 0, {tag, " R12 one outstanding"}, 64'(cd), 64'd0);
          chk(mem_rd_ecc == (aux & bus), {tag, " R2 read ecc"},
              64'(mem_rd_ecc), 64'(aux & bus));
          if (nreads == 1)
            chk(mem_rd_addr == e_a1, {tag, " R2 l1 addr"}, 64'(mem_rd_addr), 64'(e_a1));
          else
            chk(mem_rd_addr == e_a2, {tag, " R4 R5 l2 addr"}, 64'(mem_rd_addr), 64'(e_a2));
          cd = lat;
        end
      end
    end
    if (!got) chk(1'b0, {tag, " R11 done missing"}, 64'd0, 64'd1);
    @(negedge clk);
    chk(!done && req_ready, {tag, " R11 single pulse"},
        64'({done, req_ready}), 64'b01);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_va = 0; req_ifetch = 0; xlat_en = 0;
    tbl_base = 18'h2A5C3; aux_ecc_en = 0; bus_ecc_en = 0;
    mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !mem_rd_valid, "R1 R11 reset state",
        64'({req_ready, done, mem_rd_valid}), 64'b100);

    // translation disabled
    for (int n = 0; n < 8; n++)
      run_walk(mix(n), n[0], 1'b0, 1'b1, 1'b1, mix(n + 50) | 32'h12, mix(n + 60),
               1, "R9 bypass");

    // full sweep of kinds, types and attributes
    for (int t1 = 0; t1 < 4; t1++)
      for (int t2 = 0; t2 < 4; t2++)
        for (int a = 0; a < 8; a++)
          for (int p = 0; p < 2; p++)
            for (int f = 0; f < 2; f++) begin
              int          idx;
              logic [31:0] d1, d2;
              idx = (((t1 * 4 + t2) * 8 + a) * 2 + p) * 2 + f;
              d1 = (mix(idx) & 32'hFFFF_FFC0) | (32'(a[2]) << 5) | (32'(p) << 4) |
                   (32'(a[0]) << 3) | (32'(a[1]) << 2) | 32'(t1);
              d2 = (mix(idx + 1000) & 32'hFFFF_FFE0) | (32'(a[2]) << 4) |
                   (32'(a[1]) << 3) | (32'(a[0]) << 2) | 32'(t2);
              if (idx % 37 == 0) tbl_base = mix(idx + 3000)[17:0];
              run_walk(mix(idx + 2000), f[0], 1'b1, idx[0] ^ idx[3], idx[1] ^ idx[4],
                       d1, d2, 1 + (idx % 3),
                       (t1 == 2) ? "R3 section" :
                       (t1 == 0) ? "R6 l1 fault" :
                       (t1 == 1) ? "R4 coarse" : "R5 fine");
            end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule